// File: doc/BRIEF.md
# Dual-Processor Byte Mailbox Bridge

This block lets a host processor and a coprocessor pass single bytes to each other over their own buses. There are two one-byte mailboxes, one for each direction. Each mailbox has a data-available flag. Writing the data address sets that flag, and reading the incoming data address clears it. Each side polls its own status address to see whether a byte is waiting for it. The host can also see whether its own outgoing byte has been taken yet.

The host also has a read-only control window with two addresses. Reading address 0 drives the coprocessor test line high. The first such read after reset also raises a sticky release level that lets the coprocessor start running. Reading address 1 drives the test line low.

Every port uses a single-cycle strobe with a 1-bit address. Read data is registered, so it appears one clock after the strobe and is held until the next read.

Top module: `mbx_bridge`

## Requirements
- R1: After reset both flags are clear, release and test are low, and both read data outputs are 0x00. The host status reads 0x81 and the coprocessor status reads 0x01.
- R2: A host write to address 1 stores the byte in the host-to-coprocessor mailbox and sets its flag.
- R3: A coprocessor write to address 1 stores the byte in the coprocessor-to-host mailbox and sets its flag.
- R4: A read of address 1 returns the incoming mailbox byte and clears that mailbox's flag.
- R5: The host status byte (address 0) has bit 0 = 0 when a coprocessor-to-host byte is waiting and 1 otherwise. Bit 7 = 0 while the host-to-coprocessor byte is unread and 1 otherwise. Bits 6..1 read 0.
- R6: The coprocessor status byte (address 0) has bit 0 = 0 when a host-to-coprocessor byte is waiting and 1 otherwise. Bits 7..1 read 0.
- R7: A write to address 0 on either side changes no mailbox and no flag.
- R8: If a write and a data read of the same mailbox fall in the same cycle, the read returns the old byte, the flag ends set, and the new byte is stored.
- R9: A host control read at address 0 drives the test line high. The first such read after reset raises release, and release then stays high until reset.
- R10: A host control read at address 1 drives the test line low and leaves release unchanged. Every control read returns 0x00 on the host read data.
- R11: Read data appears in the cycle after the read strobe and holds while no read is made.
- R12: A data read of an empty mailbox returns the byte it last held and leaves the flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_req_i | input | 1 | Host mailbox window access strobe |
| host_we_i | input | 1 | Host write enable |
| host_addr_i | input | 1 | Host window address: 0 status, 1 data |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host registered read data |
| host_ctl_req_i | input | 1 | Host control window read strobe |
| host_ctl_addr_i | input | 1 | Control address: 0 raise test/start, 1 drop test |
| cop_req_i | input | 1 | Coprocessor window access strobe |
| cop_we_i | input | 1 | Coprocessor write enable |
| cop_addr_i | input | 1 | Coprocessor window address: 0 status, 1 data |
| cop_wdata_i | input | 8 | Coprocessor write data |
| cop_rdata_o | output | 8 | Coprocessor registered read data |
| cop_release_o | output | 1 | Sticky release level for the coprocessor |
| cop_test_o | output | 1 | Coprocessor test line |

## Verification
The hardest case to reach is a write and a read of the same mailbox landing in one cycle from opposite sides. The bench drives both port strobes in a single clock. It then checks that the reader gets the old byte, that the status still shows a byte waiting, and that a later read returns the new byte. All 256 byte values go through each direction with status polled before and after each one. This exposes any stuck or swapped data bit and any wrong flag polarity.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic {
    WIN_STATUS = 1'b0,
    WIN_DATA   = 1'b1
  } win_e;

  typedef enum logic {
    CTL_GO   = 1'b0,
    CTL_DROP = 1'b1
  } ctl_e;
endpackage

// File: rtl/mbx_channel.sv
module mbx_channel #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] data_o,
  output logic              avail_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      avail_o <= 1'b0;
    end else begin
      if (push_i) data_o <= wdata_i;
      // a push in the same cycle wins over a pop
      if (push_i)     avail_o <= 1'b1;
      else if (pop_i) avail_o <= 1'b0;
    end
  end

  a_r2_push_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> avail_o);
  a_r4_pop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> !avail_o);
  a_r8_push_stores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> (data_o == $past(wdata_i)));
  a_r7_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !push_i |=> $stable(data_o));
endmodule

// File: rtl/mbx_port.sv
module mbx_port
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              ctl_rd_i,
  output logic              push_o,
  output logic              pop_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic rd;
  assign rd     = req_i && !we_i;
  assign push_o = req_i && we_i && (win_e'(addr_i) == WIN_DATA);
  assign pop_o  = rd && (win_e'(addr_i) == WIN_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else if (rd) begin
      rdata_o <= (win_e'(addr_i) == WIN_DATA) ? in_data_i : status_i;
    end else if (ctl_rd_i) begin
      rdata_o <= '0;
    end
  end

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd && !ctl_rd_i) |=> $stable(rdata_o));
  a_r4_data_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |=> (rdata_o == $past(in_data_i)));
endmodule

// File: rtl/mbx_start_ctl.sv
module mbx_start_ctl
  import mbx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctl_rd_i,
  input  logic ctl_addr_i,
  output logic release_o,
  output logic test_o
);
  logic go, drop;
  assign go   = ctl_rd_i && (ctl_e'(ctl_addr_i) == CTL_GO);
  assign drop = ctl_rd_i && (ctl_e'(ctl_addr_i) == CTL_DROP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      release_o <= 1'b0;
      test_o    <= 1'b0;
    end else begin
      if (go)   release_o <= 1'b1;
      if (go)   test_o    <= 1'b1;
      else if (drop) test_o <= 1'b0;
    end
  end

  a_r9_test_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go |=> test_o);
  a_r9_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go |=> release_o);
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_o |=> release_o);
  a_r10_test_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop |=> !test_o);
  a_r10_no_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !go |=> $stable(release_o));
endmodule

// File: rtl/mbx_bridge.sv
module mbx_bridge #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_req_i,
  input  logic              host_we_i,
  input  logic              host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  input  logic              host_ctl_req_i,
  input  logic              host_ctl_addr_i,
  input  logic              cop_req_i,
  input  logic              cop_we_i,
  input  logic              cop_addr_i,
  input  logic [DATA_W-1:0] cop_wdata_i,
  output logic [DATA_W-1:0] cop_rdata_o,
  output logic              cop_release_o,
  output logic              cop_test_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic              h2c_avail, c2h_avail;
  logic [DATA_W-1:0] h2c_data, c2h_data;
  logic              host_push, host_pop, cop_push, cop_pop;
  logic [DATA_W-1:0] host_status, cop_status;

  // active-low flags: bit 0 incoming waiting, host bit MSB own byte unread
  always_comb begin
    host_status      = '0;
    host_status[0]   = ~c2h_avail;
    host_status[MSB] = ~h2c_avail;
    cop_status       = '0;
    cop_status[0]    = ~h2c_avail;
  end

  mbx_channel #(.DATA_W(DATA_W)) i_h2c (
    .clk_i, .rst_ni,
    .push_i(host_push), .wdata_i(host_wdata_i), .pop_i(cop_pop),
    .data_o(h2c_data), .avail_o(h2c_avail)
  );

  mbx_channel #(.DATA_W(DATA_W)) i_c2h (
    .clk_i, .rst_ni,
    .push_i(cop_push), .wdata_i(cop_wdata_i), .pop_i(host_pop),
    .data_o(c2h_data), .avail_o(c2h_avail)
  );

  mbx_port #(.DATA_W(DATA_W)) i_host_port (
    .clk_i, .rst_ni,
    .req_i(host_req_i), .we_i(host_we_i), .addr_i(host_addr_i),
    .status_i(host_status), .in_data_i(c2h_data), .ctl_rd_i(host_ctl_req_i),
    .push_o(host_push), .pop_o(host_pop), .rdata_o(host_rdata_o)
  );

  mbx_port #(.DATA_W(DATA_W)) i_cop_port (
    .clk_i, .rst_ni,
    .req_i(cop_req_i), .we_i(cop_we_i), .addr_i(cop_addr_i),
    .status_i(cop_status), .in_data_i(h2c_data), .ctl_rd_i(1'b0),
    .push_o(cop_push), .pop_o(cop_pop), .rdata_o(cop_rdata_o)
  );

  mbx_start_ctl i_start (
    .clk_i, .rst_ni,
    .ctl_rd_i(host_ctl_req_i), .ctl_addr_i(host_ctl_addr_i),
    .release_o(cop_release_o), .test_o(cop_test_o)
  );

  a_r5_host_status_fmt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_req_i && !host_we_i && !host_addr_i) |=>
      (host_rdata_o[MSB-1:1] == '0) && (host_rdata_o[0] == !$past(c2h_avail)));
  a_r6_cop_status_fmt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cop_req_i && !cop_we_i && !cop_addr_i) |=>
      (cop_rdata_o[MSB:1] == '0) && (cop_rdata_o[0] == !$past(h2c_avail)));
  a_r7_status_write_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_req_i && host_we_i && !host_addr_i && !cop_pop) |=> $stable(h2c_avail));
endmodule

// File: tb/test_mbx_bridge.sv
`timescale 1ns/1ps
module test_mbx_bridge;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_req = 0, host_we = 0, host_addr = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] host_rdata;
  logic       host_ctl_req = 0, host_ctl_addr = 0;
  logic       cop_req = 0, cop_we = 0, cop_addr = 0;
  logic [7:0] cop_wdata = 0;
  logic [7:0] cop_rdata;
  logic       cop_release, cop_test;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mbx_bridge i_mbx_bridge (
    .clk_i(clk), .rst_ni(rst_n),
    .host_req_i(host_req), .host_we_i(host_we), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
    .host_ctl_req_i(host_ctl_req), .host_ctl_addr_i(host_ctl_addr),
    .cop_req_i(cop_req), .cop_we_i(cop_we), .cop_addr_i(cop_addr),
    .cop_wdata_i(cop_wdata), .cop_rdata_o(cop_rdata),
    .cop_release_o(cop_release), .cop_test_o(cop_test)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic host_acc(input logic we, input logic a, input logic [7:0] d,
                          output logic [7:0] q);
    @(negedge clk);
    host_req = 1; host_we = we; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 0; host_we = 0;
    q = host_rdata;
  endtask

  task automatic cop_acc(input logic we, input logic a, input logic [7:0] d,
                         output logic [7:0] q);
    @(negedge clk);
    cop_req = 1; cop_we = we; cop_addr = a; cop_wdata = d;
    @(negedge clk);
    cop_req = 0; cop_we = 0;
    q = cop_rdata;
  endtask

  task automatic ctl_rd(input logic a, output logic [7:0] q);
    @(negedge clk);
    host_ctl_req = 1; host_ctl_addr = a;
    @(negedge clk);
    host_ctl_req = 0;
    q = host_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0] q, prev;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 host_rdata", host_rdata, 8'h00);
    check("R1 cop_rdata", cop_rdata, 8'h00);
    check("R1 release", {7'd0, cop_release}, 8'h00);
    check("R1 test", {7'd0, cop_test}, 8'h00);
    host_acc(0, 0, 0, q); check("R1 host status", q, 8'h81);
    cop_acc(0, 0, 0, q);  check("R1 cop status", q, 8'h01);

    // R11 hold: idle cycles keep last read value
    repeat (3) @(negedge clk);
    check("R11 cop hold", cop_rdata, 8'h01);

    // R7 status-address writes are inert
    host_acc(1, 0, 8'h5A, q);
    cop_acc(1, 0, 8'hA5, q);
    host_acc(0, 0, 0, q); check("R7 host status", q, 8'h81);
    cop_acc(0, 0, 0, q);  check("R7 cop status", q, 8'h01);
    host_acc(0, 1, 0, q); check("R7/R12 host data empty", q, 8'h00);
    cop_acc(0, 1, 0, q);  check("R7/R12 cop data empty", q, 8'h00);

    // R2 R4 R5 R6 sweep host to cop
    for (int v = 0; v < 256; v++) begin
      host_acc(1, 1, 8'(v), q);
      host_acc(0, 0, 0, q); check("R2/R5 host status pending", q, 8'h01);
      cop_acc(0, 0, 0, q);  check("R2/R6 cop status waiting", q, 8'h00);
      cop_acc(0, 1, 0, q);  check("R4 cop data", q, 8'(v));
      cop_acc(0, 0, 0, q);  check("R4/R6 cop status clear", q, 8'h01);
    end
    host_acc(0, 0, 0, q); check("R5 host status consumed", q, 8'h81);

    // R3 R4 R5 sweep cop to host
    for (int v = 0; v < 256; v++) begin
      cop_acc(1, 1, 8'(255 - v), q);
      host_acc(0, 0, 0, q); check("R3/R5 host status waiting", q, 8'h80);
      host_acc(0, 1, 0, q); check("R4 host data", q, 8'(255 - v));
      host_acc(0, 0, 0, q); check("R4/R5 host status clear", q, 8'h81);
    end

    // R12 read of empty mailbox returns last byte
    host_acc(0, 1, 0, q); check("R12 host empty read", q, 8'h00);
    host_acc(0, 0, 0, q); check("R12 host status", q, 8'h81);
    cop_acc(0, 1, 0, q);  check("R12 cop empty read", q, 8'hFF);

    // R5 both directions pending at once
    host_acc(1, 1, 8'h3C, q);
    cop_acc(1, 1, 8'hC3, q);
    host_acc(0, 0, 0, q); check("R5 both pending", q, 8'h00);
    host_acc(0, 1, 0, q); check("R4 host drain", q, 8'hC3);
    cop_acc(0, 1, 0, q);  check("R4 cop drain", q, 8'h3C);

    // R8 same-cycle write and read of host-to-cop mailbox
    host_acc(1, 1, 8'h11, q);
    @(negedge clk);
    host_req = 1; host_we = 1; host_addr = 1; host_wdata = 8'h22;
    cop_req = 1; cop_we = 0; cop_addr = 1;
    @(negedge clk);
    host_req = 0; host_we = 0; cop_req = 0;
    check("R8 old byte", cop_rdata, 8'h11);
    cop_acc(0, 0, 0, q); check("R8 flag set", q, 8'h00);
    cop_acc(0, 1, 0, q); check("R8 new byte", q, 8'h22);

    // R8 reverse direction, from an empty mailbox
    @(negedge clk);
    cop_req = 1; cop_we = 1; cop_addr = 1; cop_wdata = 8'h44;
    host_req = 1; host_we = 0; host_addr = 1;
    @(negedge clk);
    host_req = 0; cop_req = 0; cop_we = 0;
    check("R8 rev old byte", host_rdata, 8'hC3);
    host_acc(0, 0, 0, q); check("R8 rev flag set", q, 8'h80);
    host_acc(0, 1, 0, q); check("R8 rev new byte", q, 8'h44);

    // R9 R10 control window
    ctl_rd(1, q);
    check("R10 drop before start test", {7'd0, cop_test}, 8'h00);
    check("R10 drop does not release", {7'd0, cop_release}, 8'h00);
    check("R10 ctl rdata", q, 8'h00);
    ctl_rd(0, q);
    check("R9 test high", {7'd0, cop_test}, 8'h01);
    check("R9 release", {7'd0, cop_release}, 8'h01);
    ctl_rd(1, q);
    check("R10 test low", {7'd0, cop_test}, 8'h00);
    check("R9 release sticky", {7'd0, cop_release}, 8'h01);
    ctl_rd(0, q);
    check("R9 test high again", {7'd0, cop_test}, 8'h01);
    check("R9 release kept", {7'd0, cop_release}, 8'h01);
    cop_acc(1, 1, 8'h99, q);
    host_acc(0, 1, 0, prev); check("R4 host data before ctl", prev, 8'h99);
    ctl_rd(0, q); check("R10 ctl read zeroes rdata", q, 8'h00);
    repeat (4) @(negedge clk);
    check("R9 release holds idle", {7'd0, cop_release}, 8'h01);

    // R1 reset again clears everything
    host_acc(1, 1, 8'h77, q);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 release cleared", {7'd0, cop_release}, 8'h00);
    check("R1 test cleared", {7'd0, cop_test}, 8'h00);
    cop_acc(0, 0, 0, q); check("R1 cop flag cleared", q, 8'h01);

    finish_run();
  end
endmodule